// File: doc/BRIEF.md
# Timing-Reference Word Filter and Detector

This block sits in front of a video scrambler and looks at every 10-bit video word for timing-reference values: words whose upper eight bits are all zeros or all ones. When the active-low filter enable is asserted, it rewrites such a word so that its two low bits match its upper eight bits. A source that only produces 8-bit sync words then yields full 10-bit sync words of 000 or 3FF. Alongside the word it raises an active-low detect flag. The flag stays low for as long as consecutive words fall in the timing-reference range.

The data word, the filter enable and the packet-mode select are all captured in an input register. An output register then holds the conditioned word and the detect flag. Both outputs therefore come from the same captured word and stay aligned. In packet mode the filter is bypassed and the flag is held inactive. This lets the same path carry non-video payload without alteration.

Top module: `trs_word_conditioner`

## Requirements
- R1: A word presented at `word_in` before rising edge n, together with the `filt_n` and `pkt_mode` values sampled at that edge, determines `word_out` and `trs_det_n` after rising edge n+1. The latency is two clock edges, and both outputs belong to the same word.
- R2: A word counts as a timing-reference word exactly when bits [9:2] are all 0 (values 0x000 to 0x003) or all 1 (values 0x3FC to 0x3FF). Neighbouring values such as 0x004 and 0x3FB are ordinary data.
- R3: With `filt_n` = 0 and `pkt_mode` = 0, any word from 0x000 to 0x003 leaves as 0x000.
- R4: With `filt_n` = 0 and `pkt_mode` = 0, any word from 0x3FC to 0x3FF leaves as 0x3FF.
- R5: With `filt_n` = 1, every word leaves unchanged.
- R6: A word that is not a timing-reference word leaves unchanged whatever the settings of `filt_n` and `pkt_mode`.
- R7: With `pkt_mode` = 0, `trs_det_n` is 0 in the cycle that carries a timing-reference word on `word_out`, whatever the setting of `filt_n`.
- R8: `trs_det_n` is 1 in the cycle that carries a word that is not a timing-reference word, so the flag is low only across an unbroken run of timing-reference words.
- R9: With `pkt_mode` = 1, `trs_det_n` is 1 and the word leaves unchanged even when `filt_n` = 0.
- R10: While `rst_n` is 0 (synchronous, sampled on the rising edge), `word_out` is 0x000 and `trs_det_n` is 1. In the first cycle after release they remain 0x000 and 1, because the capture stage resets to packet mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Word clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| word_in | input | 10 | Incoming video word |
| filt_n | input | 1 | Low-bit squaring enable, active low |
| pkt_mode | input | 1 | High selects packet mode: no filtering, no detection |
| word_out | output | 10 | Conditioned word, two edges after capture |
| trs_det_n | output | 1 | Timing-reference detect, active low, aligned with `word_out` |

## Verification
The stimulus leans on both edges of each range: 0x003 against 0x004 and 0x3FB against 0x3FC. A classifier that tested too few or too many upper bits would leave a sync word unsquared or flag a data word. Runs of sync words broken by a single data word check that the flag goes back high on the very next word. A design that held the flag would stretch the detect pulse. Packet-mode words sent with the filter enabled expose a design that still squares bits or pulls the flag low while carrying payload. The first cycles after reset check that no phantom detect appears from the reset contents of the capture stage.

// File: rtl/trs_cond_pkg.sv
// Package: trs_cond_pkg
// Shared classification type for the timing-reference word conditioner.
// Assumes nothing beyond IEEE 1800-2017 packages.
package trs_cond_pkg;

    // Result of inspecting the upper bits of a captured word.
    typedef enum logic [1:0] {
        CLS_DATA     = 2'd0,   // upper bits mixed: ordinary data
        CLS_LOW_TRS  = 2'd1,   // upper bits all zero
        CLS_HIGH_TRS = 2'd2    // upper bits all one
    } trs_class_e;

endpackage

// File: rtl/trs_cond_in_reg.sv
// Module: trs_cond_in_reg
// Capture stage: registers the word and both controls on every rising edge.
// Assumes a synchronous active-low reset. It resets to packet mode so that
// no detect can follow from the reset contents.
module trs_cond_in_reg #(
    parameter int WORD_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] d_word,
    input  logic              d_filt_n,
    input  logic              d_pkt,
    output logic [WORD_W-1:0] q_word,
    output logic              q_filt_n,
    output logic              q_pkt
);

    // Capture all inputs together so that filter and detector see one word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_word   <= '0;
            q_filt_n <= 1'b1;
            q_pkt    <= 1'b1;
        end else begin
            q_word   <= d_word;
            q_filt_n <= d_filt_n;
            q_pkt    <= d_pkt;
        end
    end

endmodule

// File: rtl/trs_cond_classify.sv
// Module: trs_cond_classify
// Classifies a captured word by its upper WORD_W-LSB_W bits.
// Purely combinational. Assumes LSB_W < WORD_W.
module trs_cond_classify
    import trs_cond_pkg::*;
#(
    parameter int WORD_W = 10,
    parameter int LSB_W  = 2
) (
    input  logic [WORD_W-1:0] word,
    output trs_class_e        cls
);

    localparam int HI_W = WORD_W - LSB_W;

    logic [HI_W-1:0] hi_bits;
    logic            hi_zero;
    logic            hi_ones;

    assign hi_bits = word[WORD_W-1:LSB_W];
    assign hi_zero = ~|hi_bits;
    assign hi_ones = &hi_bits;

    // Map the two reductions onto the class encoding.
    always_comb begin
        if (hi_zero)      cls = CLS_LOW_TRS;
        else if (hi_ones) cls = CLS_HIGH_TRS;
        else              cls = CLS_DATA;
    end

endmodule

// File: rtl/trs_cond_filter.sv
// Module: trs_cond_filter
// Squares the low LSB_W bits of a timing-reference word to match its upper
// bits when filtering is enabled and packet mode is off. Combinational.
module trs_cond_filter
    import trs_cond_pkg::*;
#(
    parameter int WORD_W = 10,
    parameter int LSB_W  = 2
) (
    input  logic [WORD_W-1:0] word,
    input  trs_class_e        cls,
    input  logic              filt_n,
    input  logic              pkt,
    output logic [WORD_W-1:0] word_f
);

    logic apply;
    logic fill_bit;

    // Filtering applies only to sync-range words outside packet mode.
    assign apply    = !filt_n && !pkt && (cls != CLS_DATA);
    assign fill_bit = (cls == CLS_HIGH_TRS);

    for (genvar b = 0; b < WORD_W; b++) begin : g_bit
        if (b < LSB_W) begin : g_low
            assign word_f[b] = apply ? fill_bit : word[b];
        end else begin : g_high
            assign word_f[b] = word[b];
        end
    end

endmodule

// File: rtl/trs_cond_out_reg.sv
// Module: trs_cond_out_reg
// Output stage: registers the conditioned word and the active-low detect.
// Assumes the word and class come from the same captured word.
module trs_cond_out_reg
    import trs_cond_pkg::*;
#(
    parameter int WORD_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] word_f,
    input  trs_class_e        cls,
    input  logic              pkt,
    output logic [WORD_W-1:0] word_q,
    output logic              det_n_q
);

    logic det_n_d;

    // Detect is active only outside packet mode on a sync-range word.
    assign det_n_d = pkt || (cls == CLS_DATA);

    // Register word and flag together so they stay aligned.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q  <= '0;
            det_n_q <= 1'b1;
        end else begin
            word_q  <= word_f;
            det_n_q <= det_n_d;
        end
    end

endmodule

// File: rtl/trs_word_conditioner.sv
// Module: trs_word_conditioner
// Top level: capture stage, classifier, low-bit filter and output stage.
// Latency is two rising edges from input to outputs.
// Assumes a single clock and a synchronous active-low reset.
module trs_word_conditioner
    import trs_cond_pkg::*;
#(
    parameter int WORD_W = 10,
    parameter int LSB_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] word_in,
    input  logic              filt_n,
    input  logic              pkt_mode,
    output logic [WORD_W-1:0] word_out,
    output logic              trs_det_n
);

    logic [WORD_W-1:0] cap_word;
    logic              cap_filt_n;
    logic              cap_pkt;
    trs_class_e        cap_cls;
    logic [WORD_W-1:0] filt_word;

    trs_cond_in_reg #(.WORD_W(WORD_W)) i_in_reg (
        .clk      (clk),
        .rst_n    (rst_n),
        .d_word   (word_in),
        .d_filt_n (filt_n),
        .d_pkt    (pkt_mode),
        .q_word   (cap_word),
        .q_filt_n (cap_filt_n),
        .q_pkt    (cap_pkt)
    );

    trs_cond_classify #(.WORD_W(WORD_W), .LSB_W(LSB_W)) i_classify (
        .word (cap_word),
        .cls  (cap_cls)
    );

    trs_cond_filter #(.WORD_W(WORD_W), .LSB_W(LSB_W)) i_filter (
        .word   (cap_word),
        .cls    (cap_cls),
        .filt_n (cap_filt_n),
        .pkt    (cap_pkt),
        .word_f (filt_word)
    );

    trs_cond_out_reg #(.WORD_W(WORD_W)) i_out_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .word_f  (filt_word),
        .cls     (cap_cls),
        .pkt     (cap_pkt),
        .word_q  (word_out),
        .det_n_q (trs_det_n)
    );

endmodule

// File: rtl/trs_cond_checker.sv
// Module: trs_cond_checker
// Port-level properties of trs_word_conditioner, bound to the top module.
// A small counter marks when two post-reset edges have passed, so that
// $past(...,2) only looks at inputs sampled after reset.
module trs_cond_checker #(
    parameter int WORD_W = 10,
    parameter int LSB_W  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [WORD_W-1:0] word_in,
    input logic              filt_n,
    input logic              pkt_mode,
    input logic [WORD_W-1:0] word_out,
    input logic              trs_det_n
);

    localparam int HI_W = WORD_W - LSB_W;

    logic [1:0] warm_cnt;
    logic       warm;
    logic       in_low;
    logic       in_high;

    // Count edges since reset release, saturating at two.
    always_ff @(posedge clk) begin
        if (!rst_n)              warm_cnt <= 2'd0;
        else if (warm_cnt != 2'd2) warm_cnt <= warm_cnt + 2'd1;
    end

    assign warm    = (warm_cnt == 2'd2);
    assign in_low  = (word_in[WORD_W-1:LSB_W] == {HI_W{1'b0}});
    assign in_high = (word_in[WORD_W-1:LSB_W] == {HI_W{1'b1}});

    AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |=> (trs_det_n && word_out == '0)); // R10
    AST_FILT_OFF_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && $past(filt_n, 2)) |-> (word_out == $past(word_in, 2))); // R5
    AST_LOW_SQUARED: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && $past(in_low && !filt_n && !pkt_mode, 2)) |-> (word_out == '0)); // R3
    AST_HIGH_SQUARED: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && $past(in_high && !filt_n && !pkt_mode, 2)) |-> (word_out == '1)); // R4
    AST_DATA_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && $past(!in_low && !in_high, 2)) |-> (word_out == $past(word_in, 2))); // R6
    AST_DET_ON_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && $past((in_low || in_high) && !pkt_mode, 2)) |-> !trs_det_n); // R7
    AST_DET_OFF_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && $past(!in_low && !in_high, 2)) |-> trs_det_n); // R8
    AST_PKT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && $past(pkt_mode, 2)) |-> (trs_det_n && word_out == $past(word_in, 2))); // R9

endmodule

bind trs_word_conditioner trs_cond_checker #(.WORD_W(WORD_W), .LSB_W(LSB_W)) i_trs_cond_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .word_in   (word_in),
    .filt_n    (filt_n),
    .pkt_mode  (pkt_mode),
    .word_out  (word_out),
    .trs_det_n (trs_det_n)
);

// File: tb/test_trs_word_conditioner.sv
// Bench for trs_word_conditioner: directed corner cases followed by seeded
// random words, checked against expectations from bench functions. Inputs
// change on the falling edge. Outputs are checked on the falling edge two
// cycles after the word was driven.
module test_trs_word_conditioner;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] word_in = '0;
    logic       filt_n = 1'b1;
    logic       pkt_mode = 1'b0;
    logic [9:0] word_out;
    logic       trs_det_n;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // Two-deep pipeline of expectations, index 1 is the older entry.
    logic [9:0] pipe_word [2];
    logic       pipe_det  [2];
    logic       pipe_vld  [2];
    string      pipe_wtag [2];
    string      pipe_dtag [2];

    always #5 clk = ~clk;

    trs_word_conditioner i_trs_word_conditioner (
        .clk       (clk),
        .rst_n     (rst_n),
        .word_in   (word_in),
        .filt_n    (filt_n),
        .pkt_mode  (pkt_mode),
        .word_out  (word_out),
        .trs_det_n (trs_det_n)
    );

    function automatic logic is_low(input logic [9:0] w);
        return w[9:2] == 8'h00;
    endfunction

    function automatic logic is_high(input logic [9:0] w);
        return w[9:2] == 8'hFF;
    endfunction

    function automatic logic [9:0] exp_word(input logic [9:0] w, input logic f, input logic p);
        if (p || f)      return w;
        if (is_low(w))   return 10'h000;
        if (is_high(w))  return 10'h3FF;
        return w;
    endfunction

    function automatic logic exp_det(input logic [9:0] w, input logic p);
        return !(!p && (is_low(w) || is_high(w)));
    endfunction

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Check the outputs due now, then drive a new word and queue its expectation.
    task automatic step(input logic [9:0] w, input logic f, input logic p, input string extra);
        @(negedge clk);
        if (pipe_vld[1]) begin
            check(word_out == pipe_word[1], {pipe_wtag[1], " word R1"}, word_out, pipe_word[1]);
            check(trs_det_n == pipe_det[1], {pipe_dtag[1], " det R1"}, trs_det_n, pipe_det[1]);
        end
        pipe_word[1] = pipe_word[0];
        pipe_det[1]  = pipe_det[0];
        pipe_vld[1]  = pipe_vld[0];
        pipe_wtag[1] = pipe_wtag[0];
        pipe_dtag[1] = pipe_dtag[0];
        word_in  = w;
        filt_n   = f;
        pkt_mode = p;
        pipe_word[0] = exp_word(w, f, p);
        pipe_det[0]  = exp_det(w, p);
        pipe_vld[0]  = 1'b1;
        if (extra != "")                 pipe_wtag[0] = extra;
        else if (p)                      pipe_wtag[0] = "R9";
        else if (f)                      pipe_wtag[0] = "R5";
        else if (is_low(w))              pipe_wtag[0] = "R3";
        else if (is_high(w))             pipe_wtag[0] = "R4";
        else                             pipe_wtag[0] = "R6";
        if (extra != "")                 pipe_dtag[0] = extra;
        else if (p)                      pipe_dtag[0] = "R9";
        else if (is_low(w) || is_high(w)) pipe_dtag[0] = "R7";
        else                             pipe_dtag[0] = "R8";
    endtask

    function automatic logic [9:0] pick_word();
        case ($urandom % 5)
            0: return 10'($urandom % 4);
            1: return 10'h3FC | 10'($urandom % 4);
            2: return ($urandom % 2) ? 10'h004 + 10'($urandom % 4) : 10'h3F8 + 10'($urandom % 4);
            default: return 10'($urandom);
        endcase
    endfunction

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < 2; i++) pipe_vld[i] = 1'b0;
        // R10: reset values while reset is held.
        repeat (3) @(negedge clk);
        check(word_out == 10'h000, "R10 reset word", word_out, 0);
        check(trs_det_n == 1'b1, "R10 reset det", trs_det_n, 1);
        rst_n = 1'b1;
        word_in = 10'h000;
        filt_n = 1'b0;
        pkt_mode = 1'b0;
        // R10: first cycle after release shows no phantom detect.
        @(negedge clk);
        check(word_out == 10'h000, "R10 first word", word_out, 0);
        check(trs_det_n == 1'b1, "R10 first det", trs_det_n, 1);
        // Directed: R2 boundaries with filter on.
        step(10'h003, 1'b0, 1'b0, "");
        step(10'h004, 1'b0, 1'b0, "R2");
        step(10'h3FB, 1'b0, 1'b0, "R2");
        step(10'h3FC, 1'b0, 1'b0, "");
        // R8: run of sync words ended by one data word.
        step(10'h3FE, 1'b0, 1'b0, "");
        step(10'h001, 1'b1, 1'b0, "");
        step(10'h002, 1'b0, 1'b0, "");
        step(10'h155, 1'b0, 1'b0, "");
        step(10'h3FD, 1'b0, 1'b0, "");
        // R9: packet mode with filter enabled.
        step(10'h001, 1'b0, 1'b1, "");
        step(10'h3FD, 1'b0, 1'b1, "");
        step(10'h2AA, 1'b0, 1'b1, "");
        // Random mix.
        for (int n = 0; n < 3000; n++)
            step(pick_word(), 1'($urandom % 2), ($urandom % 4) == 0, "");
        step(10'h200, 1'b1, 1'b0, "");
        step(10'h200, 1'b1, 1'b0, "");
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule